// File: doc/BRIEF.md
# Hart-to-Hart Software Interrupt Controller

This block lets any hart raise a software interrupt at any other hart through a small word-addressed register space. Every hart owns one interrupt source, whose ID is the hart number plus one. Software raises a source by writing a 1 into a shared pending word. Each hart selects the sources it listens to through its own enable word. Each source has a programmable priority. Each hart takes work through its own claim/complete register. A claim read hands back the best waiting source and takes it out of the pending word. That source then stays masked for every hart until the hart that claimed it writes the same ID back.

The register bus is plain: a select strobe, a write enable, a byte address and 32-bit write data. It accepts one access per cycle and never stalls. Read data is registered. It appears in the cycle after the read access and holds until the next read. Up to 31 harts are supported, so every pending bit fits in one 32-bit word. There is one interrupt output per hart. Each output is driven from registered state, so it changes in the cycle after the access that caused the change.

Top module: `swi_ctrl`

## Requirements
- R1: Source 0 does not exist. Bit 0 of the pending word always reads 0, and writing a 1 to bit 0 has no effect.
- R2: The pending word sits at byte offset 0x1000, and source n occupies bit n. Writing 1 to a bit sets that source, and writing 0 leaves it unchanged. Bits above NUM_HARTS read 0.
- R3: Hart h's enable word sits at 0x2000 + h*0x80, and bit n enables source n for that hart. Bits 1..NUM_HARTS are stored and read back. All other bits read 0.
- R4: The priority of source n is a PRIO_W-bit value in the word at byte offset 4*n, zero-extended on read. A source whose priority is 0 never qualifies for a claim or an interrupt.
- R5: A read of hart h's claim register at 0x200004 + h*0x1000 returns the qualifying source with the highest priority, choosing the lowest ID on a tie. A source qualifies when it is pending, enabled for h, of nonzero priority and not in service. The read returns 0 when no source qualifies.
- R6: A claim read that returns a nonzero ID clears that source's pending bit in the same access.
- R7: irq[h] is 1 exactly when at least one source qualifies for hart h, as defined in R5.
- R8: A claimed source is in service and is masked for all harts. Writing its ID to the claim register of the hart that claimed it ends the service.
- R9: A completion write whose value is not the ID of a source that the same hart holds in service changes nothing.
- R10: Reads of addresses outside the map return 0, and writes to them change nothing. This includes unaligned addresses, the priority word of source 0 and the claim registers of absent harts.
- R11: Read data appears in the cycle after the read access and holds through write cycles until the next read.
- R12: After reset all pending, enable, priority and in-service state is zero, no irq is set, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_HARTS | Software interrupt, one per hart |

## Verification
The assertions assume that the bus carries at most one access per cycle and that a read is only ever a read. The whole protocol rests on these two conditions. Because of them, a claim can never race a pending-word write or a completion in the same cycle. The bench drives exactly one access per call, with the select strobe dropped between calls. Its random phase chooses only from legal operations: pending-word writes, enable writes, priority writes, claim reads, completion writes with arbitrary IDs, and reads of mapped and unmapped addresses.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_PEND,
    REG_EN,
    REG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [4:0] idx;
  } reg_sel_t;

  localparam logic [31:0] PEND_BASE    = 32'h0000_1000;
  localparam logic [31:0] EN_BASE      = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE    = 32'h0000_0080;
  localparam logic [31:0] CLAIM_BASE   = 32'h0020_0004;
  localparam logic [31:0] CLAIM_STRIDE = 32'h0000_1000;
endpackage

// File: rtl/swi_regdec.sv
module swi_regdec
  import swi_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam logic [31:0] PRIO_LAST = 32'(4 * NUM_HARTS);
  localparam logic [31:0] EN_END    = 32'(EN_BASE + NUM_HARTS * EN_STRIDE);
  localparam logic [31:0] CLAIM_END = 32'(CLAIM_BASE + NUM_HARTS * CLAIM_STRIDE);

  logic [31:0] a;
  logic [31:0] off_en;
  logic [31:0] off_cl;

  always_comb begin
    a = '0;
    a[ADDR_W-1:0] = addr;
    off_en = a - EN_BASE;
    off_cl = a - CLAIM_BASE;
    sel.kind = REG_NONE;
    sel.idx  = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= 32'h4 && a <= PRIO_LAST) begin
        sel.kind = REG_PRIO;
        sel.idx  = a[6:2];
      end else if (a == PEND_BASE) begin
        sel.kind = REG_PEND;
      end else if (a >= EN_BASE && a < EN_END) begin
        if (off_en[6:0] == 7'd0) begin
          sel.kind = REG_EN;
          sel.idx  = off_en[11:7];
        end
      end else if (a >= CLAIM_BASE && a < CLAIM_END) begin
        if (off_cl[11:0] == 12'd0) begin
          sel.kind = REG_CLAIM;
          sel.idx  = off_cl[16:12];
        end
      end
    end
  end
endmodule

// File: rtl/swi_pick.sv
module swi_pick #(
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3
) (
  input  logic [31:0]             cand,
  input  logic [31:0][PRIO_W-1:0] prio,
  output logic [4:0]              id,
  output logic                    any
);
  logic [PRIO_W-1:0] best;

  // Scan from the top ID down; ">=" lets a lower ID take over an equal priority.
  always_comb begin
    id   = '0;
    best = '0;
    for (int s = NUM_HARTS; s >= 1; s--) begin
      if (cand[s] && prio[s] >= best) begin
        best = prio[s];
        id   = 5'(s);
      end
    end
    any = |cand;
  end
endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl
  import swi_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq
);
  localparam int          HW       = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam logic [32:0] ONES     = (33'h1 << (NUM_HARTS + 1)) - 33'h1;
  localparam logic [31:0] SRC_MASK = ONES[31:0] & ~32'h1;

  reg_sel_t   dec_sel;
  reg_kind_e  acc_kind;
  logic [4:0] acc_idx;
  logic [HW-1:0] acc_hart;

  swi_regdec #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (dec_sel)
  );

  assign acc_kind = dec_sel.kind;
  assign acc_idx  = dec_sel.idx;
  assign acc_hart = acc_idx[HW-1:0];

  logic [31:0]             pend_q;
  logic [31:0][PRIO_W-1:0] prio_q;
  logic [31:0]             en_q  [NUM_HARTS];
  logic [31:0]             own_q [NUM_HARTS];
  logic [31:0]             busy;
  logic [31:0]             prio_nz;
  logic [4:0]              pick_id [NUM_HARTS];
  logic [NUM_HARTS-1:0]    pick_any;

  for (genvar s = 0; s < 32; s++) begin : g_nz
    if (s >= 1 && s <= NUM_HARTS) begin : g_src
      assign prio_nz[s] = |prio_q[s];
    end else begin : g_none
      assign prio_nz[s] = 1'b0;
    end
  end

  always_comb begin
    busy = '0;
    for (int h = 0; h < NUM_HARTS; h++) busy = busy | own_q[h];
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [31:0] cand;
    assign cand = pend_q & en_q[h] & prio_nz & ~busy;
    swi_pick #(.NUM_HARTS(NUM_HARTS), .PRIO_W(PRIO_W)) u_pick (
      .cand (cand),
      .prio (prio_q),
      .id   (pick_id[h]),
      .any  (pick_any[h])
    );
  end

  assign irq = pick_any;

  logic [4:0]  claim_id;
  logic        claim_any;
  logic [4:0]  cmpl_id;
  logic        cmpl_ok;
  logic [31:0] rd_val;

  assign claim_id  = pick_id[acc_hart];
  assign claim_any = pick_any[acc_hart];
  assign cmpl_id   = bus_wdata[4:0];
  assign cmpl_ok   = (bus_wdata[31:5] == 27'd0) && own_q[acc_hart][cmpl_id];

  always_comb begin
    rd_val = '0;
    case (acc_kind)
      REG_PRIO:  rd_val[PRIO_W-1:0] = prio_q[acc_idx];
      REG_PEND:  rd_val = pend_q;
      REG_EN:    rd_val = en_q[acc_hart];
      REG_CLAIM: rd_val[4:0] = claim_id;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      prio_q    <= '0;
      bus_rdata <= '0;
      for (int h = 0; h < NUM_HARTS; h++) begin
        en_q[h]  <= '0;
        own_q[h] <= '0;
      end
    end else if (bus_sel) begin
      if (!bus_we) bus_rdata <= rd_val;
      case (acc_kind)
        REG_PRIO: if (bus_we) prio_q[acc_idx] <= bus_wdata[PRIO_W-1:0];
        REG_PEND: if (bus_we) pend_q <= pend_q | (bus_wdata & SRC_MASK);
        REG_EN:   if (bus_we) en_q[acc_hart] <= bus_wdata & SRC_MASK;
        REG_CLAIM: begin
          if (bus_we) begin
            if (cmpl_ok) own_q[acc_hart][cmpl_id] <= 1'b0;
          end else if (claim_any) begin
            pend_q[claim_id]           <= 1'b0;
            own_q[acc_hart][claim_id]  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swi_ctrl_chk.sv
module swi_ctrl_chk
  import swi_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_HARTS-1:0] irq,
  input reg_kind_e            kind,
  input logic [31:0]          pend_q,
  input logic [31:0]          busy
);
  logic claim_rd;
  assign claim_rd = bus_sel && !bus_we && kind == REG_CLAIM;

  assert_src0_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && kind == REG_PEND) |=> !bus_rdata[0]);

  assert_zero_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && kind == REG_PEND && bus_wdata == 32'd0) |=> $stable(pend_q));

  assert_claim_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> bus_rdata <= 32'(NUM_HARTS));

  assert_claim_clears_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> (bus_rdata == 32'd0 || !pend_q[bus_rdata[4:0]]));

  assert_claim_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> (bus_rdata == 32'd0 || busy[bus_rdata[4:0]]));

  assert_bad_complete_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && kind == REG_CLAIM &&
     (bus_wdata == 32'd0 || bus_wdata > 32'(NUM_HARTS))) |=> $stable(busy));

  assert_reserved_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && kind == REG_NONE) |=> bus_rdata == 32'd0);

  assert_write_holds_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> $stable(bus_rdata));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
    assert_irq_needs_work_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[h] |-> (pend_q & ~busy) != 32'd0);
  end
endmodule

bind swi_ctrl swi_ctrl_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .kind      (acc_kind),
  .pend_q    (pend_q),
  .busy      (busy)
);

// File: tb/test_swi_ctrl.sv
`timescale 1ns/1ps
module test_swi_ctrl;
  localparam int N      = 4;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 22;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [N-1:0]      irq;

  always #2.5 clk = ~clk;

  swi_ctrl #(.NUM_HARTS(N), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) i_swi_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;
  bit live     = 0;

  // reference model
  bit [31:0] m_pend;
  bit [31:0] m_en [N];
  int        m_prio [32];
  int        m_owner [32];
  bit [31:0] m_rdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_best(int h);
    int best = 0;
    int bp = 0;
    for (int s = 1; s <= N; s++)
      if (m_pend[s] && m_en[h][s] && m_prio[s] != 0 && m_owner[s] < 0 && m_prio[s] > bp) begin
        best = s;
        bp = m_prio[s];
      end
    return best;
  endfunction

  function automatic logic [N-1:0] m_irq();
    logic [N-1:0] r;
    for (int h = 0; h < N; h++) r[h] = (m_best(h) != 0);
    return r;
  endfunction

  function automatic bit [31:0] src_bits(bit [31:0] v);
    bit [31:0] r = '0;
    for (int s = 1; s <= N; s++) r[s] = v[s];
    return r;
  endfunction

  task automatic m_apply(bit we, int addr, bit [31:0] wd);
    bit [31:0] rv = '0;
    if (addr % 4 == 0 && addr >= 4 && addr <= 4 * N) begin
      if (we) m_prio[addr / 4] = int'(wd) & ((1 << PRIO_W) - 1);
      rv = 32'(m_prio[addr / 4]);
    end else if (addr == 32'h1000) begin
      if (we) m_pend = m_pend | src_bits(wd);
      rv = m_pend;
    end else if (addr >= 32'h2000 && addr < 32'h2000 + N * 32'h80 && (addr - 32'h2000) % 32'h80 == 0) begin
      int h = (addr - 32'h2000) / 32'h80;
      if (we) m_en[h] = src_bits(wd);
      rv = m_en[h];
    end else if (addr >= 32'h200004 && (addr - 32'h200004) % 32'h1000 == 0 &&
                 (addr - 32'h200004) / 32'h1000 < N) begin
      int h = (addr - 32'h200004) / 32'h1000;
      if (we) begin
        if (wd >= 1 && wd <= N && m_owner[wd] == h) m_owner[wd] = -1;
      end else begin
        int b = m_best(h);
        rv = 32'(b);
        if (b != 0) begin
          m_pend[b] = 1'b0;
          m_owner[b] = h;
        end
      end
    end
    if (!we) m_rdata = rv;
  endtask

  // one bus access; called and returns at a falling edge
  task automatic acc(string req, bit we, int addr, bit [31:0] wd);
    bus_sel   = 1'b1;
    bus_we    = we;
    bus_addr  = ADDR_W'(addr);
    bus_wdata = wd;
    @(posedge clk);
    #1 m_apply(we, addr, wd);
    @(negedge clk);
    bus_sel = 1'b0;
    chk(req, bus_rdata, m_rdata);
  endtask

  // R7: every cycle, interrupt lines against the model
  always @(negedge clk)
    if (live) chk("R7 irq", 32'(irq), 32'(m_irq()));

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    m_pend = '0;
    m_rdata = '0;
    for (int h = 0; h < N; h++) m_en[h] = '0;
    for (int s = 0; s < 32; s++) begin
      m_prio[s] = 0;
      m_owner[s] = -1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 irq", 32'(irq), 32'd0);
    chk("R12 rdata", bus_rdata, 32'd0);
    live = 1;
    acc("R12 pend", 0, 32'h1000, 0);
    acc("R12 prio", 0, 32'h4, 0);

    // R4 priorities
    acc("R4", 1, 32'h4, 2);
    acc("R4", 1, 32'h8, 32'hFD);
    acc("R4", 1, 32'hC, 5);
    acc("R4", 1, 32'h10, 0);
    acc("R4", 0, 32'h8, 0);
    chk("R4 masked", bus_rdata, 32'd5);

    // R3 enables
    acc("R3", 1, 32'h2000, 32'hFFFF_FFFF);
    acc("R3", 0, 32'h2000, 0);
    chk("R3 readback", bus_rdata, 32'h1E);
    acc("R3", 1, 32'h2080, 32'h4);
    acc("R3", 1, 32'h2100, 32'h8);
    acc("R3", 1, 32'h2180, 32'h10);
    acc("R3", 0, 32'h2100, 0);
    chk("R3 hart2", bus_rdata, 32'h8);

    // R1 / R2 pending
    acc("R1", 1, 32'h1000, 32'h1);
    acc("R1", 0, 32'h1000, 0);
    chk("R1 bit0", bus_rdata, 32'h0);
    acc("R2", 1, 32'h1000, 32'hFFFF_FFFE);
    acc("R2", 1, 32'h1000, 32'h0);
    acc("R2", 0, 32'h1000, 0);
    chk("R2 zero write", bus_rdata, 32'h1E);
    chk("R7 pattern", 32'(irq), 32'b0111);

    // R5 / R6 claims on hart 0
    acc("R5", 0, 32'h200004, 0);
    chk("R5 tie low id", bus_rdata, 32'd2);
    acc("R5", 0, 32'h200004, 0);
    chk("R5 next", bus_rdata, 32'd3);
    acc("R5", 0, 32'h200004, 0);
    chk("R5 low prio", bus_rdata, 32'd1);
    acc("R4", 0, 32'h200004, 0);
    chk("R4 zero prio never claimed", bus_rdata, 32'd0);
    acc("R6", 0, 32'h1000, 0);
    chk("R6 cleared", bus_rdata, 32'h10);

    // R8 / R9 in-service masking
    acc("R8", 1, 32'h1000, 32'h4);
    chk("R8 masked", 32'(irq[1]), 32'd0);
    acc("R8", 0, 32'h201004, 0);
    chk("R8 masked claim", bus_rdata, 32'd0);
    acc("R9", 1, 32'h201004, 2);
    chk("R9 other hart", 32'(irq[1]), 32'd0);
    acc("R9", 1, 32'h200004, 7);
    acc("R9", 1, 32'h200004, 32'h22);
    chk("R9 bad id", 32'(irq[1]), 32'd0);
    acc("R8", 1, 32'h200004, 2);
    chk("R8 released", 32'(irq[1]), 32'd1);
    acc("R8", 0, 32'h201004, 0);
    chk("R8 reclaim", bus_rdata, 32'd2);

    // R10 reserved
    acc("R10", 0, 32'h0, 0);
    acc("R10", 0, 32'h1004, 0);
    acc("R10", 0, 32'h2004, 0);
    acc("R10", 0, 32'h14, 0);
    acc("R10", 0, 32'h204004, 0);
    acc("R10", 0, 32'h1002, 0);
    chk("R10 unaligned", bus_rdata, 32'd0);
    acc("R10", 1, 32'h1004, 32'hFFFF_FFFF);
    acc("R10", 1, 32'h0, 32'hFFFF_FFFF);
    acc("R10", 1, 32'h1001, 32'hFFFF_FFFF);
    acc("R10", 0, 32'h1000, 0);
    chk("R10 pend untouched", bus_rdata, 32'h10);
    acc("R11", 1, 32'h1000, 0);
    chk("R11 hold", bus_rdata, 32'h10);

    // mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 7);
      int h = $urandom_range(0, N - 1);
      case (op)
        0: acc("R2", 1, 32'h1000, $urandom);
        1: acc("R3", 1, 32'h2000 + h * 32'h80, $urandom);
        2: acc("R4", 1, 4 * $urandom_range(1, N), $urandom);
        3, 4: acc("R5", 0, 32'h200004 + h * 32'h1000, 0);
        5: acc("R8", 1, 32'h200004 + h * 32'h1000, $urandom_range(0, N + 1));
        6: acc("R10", 0, 4 * $urandom_range(0, 40), 0);
        default: acc("R11", $urandom_range(0, 1), 32'h1000, 0);
      endcase
    end

    live = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule